// File: doc/BRIEF.md
# Interrupt Acknowledge Priority Resolver

This block holds one sticky request flag and one priority level for each of a set of maskable interrupt sources. Every cycle it picks, among the sources whose flag is set and whose level is non-zero, the one with the highest level. It raises a registered interrupt-pending output to the CPU when that winner's level is strictly above the CPU's current processor level.

The CPU takes the interrupt by reading address zero on the block's read port. One cycle later the port returns the winner's source number and level. The same read clears the winner's request flag. Any read of address zero has this effect, including a stray software read, so such a read silently consumes the highest-priority pending request.

Each source has one configuration write. Its three low bits set the level, and level 0 means disabled. Its top bit, when written as 0, clears the request flag. After reset the pending output is held low until the CPU reports that its first instruction has retired.

Top module: `irq_ack_resolver`

## Requirements
- R1: After a synchronous reset, all request flags and levels are 0, `rd_data` is 0 and `irq_pending` is 0.
- R2: One cycle after a read with `rd_addr` = 0, `rd_data` holds the winner's source number in bits [IDX_W-1:0] and its level in bits [10:8]. All other bits are 0. The winner is the source with the highest level among those whose flag is 1 and whose level is non-zero.
- R3: When several candidates share the highest level, the lowest source number wins.
- R4: A read of address zero clears the winner's request flag in the same edge, whatever issued the read.
- R5: A read of address zero when no source is a candidate returns 0 and clears no flag.
- R6: A source at level 0 is never selected, but its flag still latches. The latched request is offered once a non-zero level is written with flag bit 1.
- R7: `irq_pending` is 1 exactly when a winner exists and its level is greater than `cpu_ipl`. It is registered and lags its inputs by one cycle.
- R8: After reset, `irq_pending` stays 0 until the first `insn_retire` pulse. It can go high from the second cycle after that pulse.
- R9: A `req_pulse` bit sets its flag even when an acknowledge or a software clear targets that flag in the same cycle.
- R10: A configuration write with `cfg_wdata[3]` = 0 clears the selected flag. With `cfg_wdata[3]` = 1 the flag is left unchanged, and such a write never sets it. The level is always written to `cfg_wdata[2:0]`.
- R11: A read at any non-zero address returns 0 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pulse | input | N_SRC | One-cycle request strobes, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IDX_W | Source addressed by the configuration write |
| cfg_wdata | input | 4 | Bits [2:0] are the level; bit 3 = 0 clears the flag |
| cpu_ipl | input | 3 | Current processor interrupt level |
| insn_retire | input | 1 | Pulse on each retired instruction |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address; 0 is the acknowledge address |
| rd_data | output | DATA_W | Registered read result |
| irq_pending | output | 1 | Registered interrupt request to the CPU |

## Verification
On every cycle the assertions check the following:
- the clear of the winner's flag after an acknowledge;
- the survival of flags that were set during a clear;
- the all-zero result of empty reads and of reads at other addresses;
- the silence of `irq_pending` before the first retired instruction.

Some behaviour can be shown only by the bench's swept scenarios. This covers:
- choosing the right winner across level patterns that include ties and disabled sources;
- the comparison against every processor level;
- the order in which repeated acknowledges drain the pending set;
- a dormant level-0 request that becomes visible later.

// File: rtl/irq_res_pkg.sv
`timescale 1ns/1ps
package irq_res_pkg;
  localparam int unsigned LVL_W   = 3;
  // bit position of the level field inside the read word
  localparam int unsigned LVL_LSB = 8;
  // bit of the configuration word that, written as 0, clears the flag
  localparam int unsigned KEEP_BIT = LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  // true when the challenger must replace the incumbent; ties keep the incumbent
  function automatic logic beats(input logic c_v, input lvl_t c_l,
                                 input logic i_v, input lvl_t i_l);
    return c_v && (!i_v || (c_l > i_l));
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  output logic [N_SRC-1:0] flags_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags_o[i] <= 1'b0;
      else if (set_i[i])                 // set beats any clear
        flags_o[i] <= 1'b1;
      else if (ack_clr_i[i] || sw_clr_i[i])
        flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_level_regs.sv
`timescale 1ns/1ps
module irq_level_regs
  import irq_res_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            sel_i,
  input  lvl_t                        lvl_i,
  output logic [N_SRC-1:0][LVL_W-1:0] lvls_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)
        lvls_o[i] <= '0;
      else if (we_i && (int'(sel_i) == i))
        lvls_o[i] <= lvl_i;
    end
  end
endmodule

// File: rtl/irq_prio_tree.sv
`timescale 1ns/1ps
module irq_prio_tree
  import irq_res_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int NP    = 1 << IDX_W,
  localparam int NODES = 2 * NP - 1
) (
  input  logic [N_SRC-1:0]            flags_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvls_i,
  output logic                        win_valid_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output lvl_t                        win_lvl_o
);
  // heap layout: node k has children 2k+1 (lower numbers) and 2k+2
  logic             nv [NODES];
  lvl_t             nl [NODES];
  logic [IDX_W-1:0] nx [NODES];

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N_SRC) begin : g_real
      assign nv[NP-1+i] = flags_i[i] && (lvls_i[i] != '0);
      assign nl[NP-1+i] = lvls_i[i];
    end else begin : g_pad
      assign nv[NP-1+i] = 1'b0;
      assign nl[NP-1+i] = '0;
    end
    assign nx[NP-1+i] = IDX_W'(i);
  end

  for (genvar k = 0; k < NP - 1; k++) begin : g_node
    logic take_hi;
    assign take_hi = beats(nv[2*k+2], nl[2*k+2], nv[2*k+1], nl[2*k+1]);
    assign nv[k]   = nv[2*k+1] || nv[2*k+2];
    assign nl[k]   = take_hi ? nl[2*k+2] : nl[2*k+1];
    assign nx[k]   = take_hi ? nx[2*k+2] : nx[2*k+1];
  end

  assign win_valid_o = nv[0];
  assign win_idx_o   = nx[0];
  assign win_lvl_o   = nv[0] ? nl[0] : '0;
endmodule

// File: rtl/irq_boot_gate.sv
`timescale 1ns/1ps
module irq_boot_gate (
  input  logic clk,
  input  logic rst,
  input  logic retire_i,
  output logic open_o
);
  always_ff @(posedge clk) begin
    if (rst)
      open_o <= 1'b0;
    else if (retire_i)
      open_o <= 1'b1;
  end
endmodule

// File: rtl/irq_ack_resolver.sv
`timescale 1ns/1ps
module irq_ack_resolver
  import irq_res_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  req_pulse,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [LVL_W:0]    cfg_wdata,
  input  logic [LVL_W-1:0]  cpu_ipl,
  input  logic              insn_retire,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pending
);
  logic [N_SRC-1:0]            flags;
  logic [N_SRC-1:0][LVL_W-1:0] lvls;
  logic                        win_valid;
  logic [IDX_W-1:0]            win_idx;
  lvl_t                        win_lvl;
  logic                        gate_open;
  logic                        ack;
  logic [N_SRC-1:0]            ack_clr;
  logic [N_SRC-1:0]            sw_clr;
  logic [DATA_W-1:0]           ack_word;

  assign ack = rd_en && (rd_addr == '0);

  always_comb begin
    ack_clr = '0;
    sw_clr  = '0;
    if (ack && win_valid)
      ack_clr[win_idx] = 1'b1;
    if (cfg_we && !cfg_wdata[KEEP_BIT] && (int'(cfg_sel) < N_SRC))
      sw_clr[cfg_sel] = 1'b1;
  end

  always_comb begin
    ack_word = '0;
    ack_word[IDX_W-1:0]       = win_idx;
    ack_word[LVL_LSB +: LVL_W] = win_lvl;
    if (!win_valid)
      ack_word = '0;
  end

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (req_pulse),
    .ack_clr_i (ack_clr),
    .sw_clr_i  (sw_clr),
    .flags_o   (flags)
  );

  irq_level_regs #(.N_SRC(N_SRC)) u_lvls (
    .clk    (clk),
    .rst    (rst),
    .we_i   (cfg_we),
    .sel_i  (cfg_sel),
    .lvl_i  (cfg_wdata[LVL_W-1:0]),
    .lvls_o (lvls)
  );

  irq_prio_tree #(.N_SRC(N_SRC)) u_tree (
    .flags_i     (flags),
    .lvls_i      (lvls),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl)
  );

  irq_boot_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .retire_i (insn_retire),
    .open_o   (gate_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      irq_pending <= 1'b0;
    end else begin
      rd_data     <= ack ? ack_word : '0;
      irq_pending <= gate_open && win_valid && (win_lvl > cpu_ipl);
    end
  end
endmodule

// File: rtl/irq_ack_resolver_chk.sv
`timescale 1ns/1ps
module irq_ack_resolver_chk
  import irq_res_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  req_pulse,
  input logic              insn_retire,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_pending,
  input logic [N_SRC-1:0]  flags,
  input logic              win_valid,
  input logic [IDX_W-1:0]  win_idx
);
  logic retired_seen;
  logic hit0;
  assign hit0 = rd_en && (rd_addr == '0);

  always_ff @(posedge clk) begin
    if (rst) retired_seen <= 1'b0;
    else if (insn_retire) retired_seen <= 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq_pending));

  // R4
  ack_clears_winner_chk: assert property (@(posedge clk) disable iff (rst)
    (hit0 && win_valid && !req_pulse[win_idx]) |=> !flags[$past(win_idx)]);

  // R5
  empty_ack_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hit0 && !win_valid) |=> (rd_data == '0));

  // R8
  boot_block_chk: assert property (@(posedge clk) disable iff (rst)
    !retired_seen |=> !irq_pending);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (req_pulse != '0) |=> ((flags & $past(req_pulse)) == $past(req_pulse)));

  // R11
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != '0) |=> (rd_data == '0));

  // R2
  level_field_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[LVL_LSB +: LVL_W] == '0) |-> (rd_data == '0));
endmodule

bind irq_ack_resolver irq_ack_resolver_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_pulse   (req_pulse),
  .insn_retire (insn_retire),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .irq_pending (irq_pending),
  .flags       (flags),
  .win_valid   (win_valid),
  .win_idx     (win_idx)
);

// File: tb/sim_irq_ack_resolver.sv
`timescale 1ns/1ps
module sim_irq_ack_resolver;
  localparam int N = 8;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_pulse = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [3:0]    cfg_wdata = '0;
  logic [2:0]    cpu_ipl = '0;
  logic          insn_retire = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_pending;

  int vectors = 0;
  int fails = 0;
  bit mflag [N];
  int mlvl  [N];

  always #2 clk = ~clk;   // 250 MHz

  irq_ack_resolver #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .req_pulse(req_pulse), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cpu_ipl(cpu_ipl),
    .insn_retire(insn_retire), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_pending(irq_pending));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model winner: strict > keeps the lower number on ties
  function automatic int model_word(output int wl);
    int bi = -1;
    wl = 0;
    for (int i = 0; i < N; i++)
      if (mflag[i] && mlvl[i] != 0 && mlvl[i] > wl) begin
        bi = i; wl = mlvl[i];
      end
    return (bi < 0) ? 0 : ((wl << 8) | bi);
  endfunction

  task automatic wr_cfg(input int src, input int lvl, input bit keep);
    cfg_we = 1'b1; cfg_sel = 3'(src); cfg_wdata = {keep, 3'(lvl)};
    tick();
    cfg_we = 1'b0;
    mlvl[src] = lvl;
    if (!keep) mflag[src] = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    req_pulse = m;
    tick();
    req_pulse = '0;
    for (int i = 0; i < N; i++) if (m[i]) mflag[i] = 1'b1;
  endtask

  // read address zero; model clears its winner
  task automatic ack_read(output int data);
    int wl, w;
    w = model_word(wl);
    rd_en = 1'b1; rd_addr = '0;
    tick();
    rd_en = 1'b0;
    data = int'(rd_data);
    if (w != 0) mflag[w & 7] = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int d, wl, w;
    for (int i = 0; i < N; i++) begin mflag[i] = 0; mlvl[i] = 0; end
    repeat (3) tick();
    rst = 1'b0;
    check(int'(rd_data), 0, "R1 rd_data after reset");
    check(int'(irq_pending), 0, "R1 pending after reset");
    ack_read(d);
    check(d, 0, "R1/R5 read after reset");

    // R8: pending blocked until first retire
    wr_cfg(2, 5, 1'b1);
    pulse(8'h04);
    repeat (4) tick();
    check(int'(irq_pending), 0, "R8 blocked before retire");
    insn_retire = 1'b1; tick(); insn_retire = 1'b0;
    check(int'(irq_pending), 0, "R8 still low one cycle after retire");
    tick();
    check(int'(irq_pending), 1, "R8 open after retire");
    ack_read(d);
    check(d, 'h502, "R2 single source");
    ack_read(d);
    check(d, 0, "R4 flag cleared by ack");

    // sweep of level patterns, request masks and processor levels
    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < N; i++) wr_cfg(i, ((i * i + 3 * t) >> 1) % 8, 1'b0);
      pulse(8'((t * 37 + 11) ^ (t << 4)));
      for (int p = 0; p < 8; p++) begin
        cpu_ipl = 3'(p);
        tick(); tick();
        w = model_word(wl);
        check(int'(irq_pending), (w != 0 && wl > p) ? 1 : 0, "R7 pending vs ipl");
      end
      cpu_ipl = '0;
      for (int r = 0; r < N + 1; r++) begin
        w = model_word(wl);
        ack_read(d);
        check(d, w, (w != 0) ? "R2/R3/R4 ack order" : "R5 empty ack");
      end
    end

    for (int i = 0; i < N; i++) wr_cfg(i, 0, 1'b0);
    // R6: level 0 latches but is not offered
    pulse(8'h10);
    ack_read(d);
    check(d, 0, "R6 level-0 source hidden");
    wr_cfg(4, 6, 1'b1);
    ack_read(d);
    check(d, 'h604, "R6 latched request offered");

    // R9: set beats ack clear
    wr_cfg(1, 7, 1'b0);
    pulse(8'h02);
    rd_en = 1'b1; rd_addr = '0; req_pulse = 8'h02;
    tick();
    rd_en = 1'b0; req_pulse = '0;
    check(int'(rd_data), 'h701, "R9 ack data");
    ack_read(d);
    check(d, 'h701, "R9 flag kept over ack");
    // R9: set beats software clear
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 4'b0111; req_pulse = 8'h02;
    tick();
    cfg_we = 1'b0; req_pulse = '0; mflag[1] = 1'b1;
    ack_read(d);
    check(d, 'h701, "R9 flag kept over sw clear");

    // R10
    pulse(8'h02);
    wr_cfg(1, 7, 1'b1);
    ack_read(d);
    check(d, 'h701, "R10 keep bit leaves flag set");
    wr_cfg(1, 7, 1'b1);
    ack_read(d);
    check(d, 0, "R10 keep bit does not set");
    pulse(8'h02);
    wr_cfg(1, 7, 1'b0);
    ack_read(d);
    check(d, 0, "R10 write 0 clears flag");

    // R11
    pulse(8'h02);
    rd_en = 1'b1; rd_addr = 16'h0005;
    tick();
    rd_en = 1'b0; rd_addr = '0;
    check(int'(rd_data), 0, "R11 other address reads zero");
    ack_read(d);
    check(d, 'h701, "R11 flag untouched");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule